// File: doc/BRIEF.md
# Serial Converter Control-Byte Port

This block is the digital side of a sampling converter's serial port. It runs on the externally supplied serial clock and is enabled by an active-low chip select. While idle it watches the serial data input for a HIGH bit. That bit starts an 8-bit control byte. The byte chooses an input channel, single-ended or differential operation, a power-down code and a reduced-resolution request. When the byte is complete the block latches these fields. It also freezes the value on a parallel sample input, which stands in for the analog sample. The frozen value is then returned MSB-first on the serial data output.

A host issues a control byte and then clocks out the result. The block reports where it is in the frame on two flags. One flag shows that the tracking (acquire) window is open. The other shows that the value is held and being converted and shifted out. The start-bit search runs again as soon as a byte is finished. A host can therefore send the next control byte while the previous result is still leaving the port. This allows back-to-back frames every 15 clocks at full resolution and every 11 clocks at reduced resolution.

Top module: `sadc_port`

## Requirements
- R1: While reset is low, and on release, the acquire flag, the hold flag, all decoded fields and the serial data output are 0.
- R2: When no byte is in progress, LOW data-input bits are ignored. The first HIGH bit sampled on a rising clock edge is the start bit. The byte is taken MSB first as: start, channel[2:0], mode, single-ended, power-down[1:0].
- R3: The acquire flag rises on the rising edge that samples the last channel bit (the fourth bit of the byte). It falls on the edge that samples the eighth bit. It is therefore high for four clock periods.
- R4: On the rising edge that samples the eighth bit, the block latches the channel, single-ended and power-down fields. It captures the parallel sample input on the same edge, and the hold flag rises.
- R5: On the falling edge that follows the eighth bit, the output is driven LOW (busy bit). On each later falling edge the next result bit is driven, MSB first.
- R6: The result length is 12 bits when the mode pin is LOW, whatever the mode bit says. It is also 12 bits when the mode pin is HIGH and the mode bit is 0. It is 8 bits (the top eight bits of the sample) when both are HIGH. The hold flag falls on the rising edge after the last result bit's period, and the output is LOW after that.
- R7: A start bit may arrive while a result is still shifting out. Frames whose start bits are 15 clocks apart at 12 bits, or 11 clocks apart at 8 bits, each return their own result intact.
- R8: While chip select is HIGH, the output enable is 0 and the output is LOW. A rising edge with chip select HIGH abandons any partial byte or conversion and clears both phase flags. The start-bit search then begins again.
- R9: The decoded fields change only on the eighth-bit edge of a complete byte. An abandoned partial byte leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Serial clock; data in on rising, data out on falling edges |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| din | input | 1 | Serial control data |
| modePin | input | 1 | Enables the reduced-resolution request when HIGH |
| sampleIn | input | 12 | Parallel stand-in for the analog sample |
| dout | output | 1 | Serial result, MSB first |
| doutOe | output | 1 | Output enable for dout (0 = high impedance) |
| chanSel | output | 3 | Latched channel select |
| singleEnded | output | 1 | Latched single-ended (1) / differential (0) select |
| pwrDown | output | 2 | Latched power-down code |
| acqActive | output | 1 | Acquire window open |
| holdActive | output | 1 | Sample held; conversion/shift-out in progress |

## Verification
For a start bit on clock c, the acquire flag is due just after the rising edges of clocks c+3 through c+6. The hold flag and the new fields are due from the rising edge of clock c+7. The busy bit appears after the falling edge of clock c+7, and result bit j after the falling edge of clock c+8+j. The bench writes every stimulus and expected value into per-cycle tables built from these offsets. It samples the flags and fields one time unit after each rising edge, and the output and its enable one time unit after each falling edge. Every cycle of every frame is compared against its table entry.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int MAX_RES = 16;
  localparam int SEL_W = $clog2(MAX_RES);

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic             shiftIn;  // take din into the byte shifter
    logic             loadCtl;  // eighth bit present: latch fields, freeze sample
    logic             drive;    // a result bit is due on the next falling edge
    logic [SEL_W-1:0] bitSel;   // which bit of the frozen sample
  } seqStrobe_t;

  // Decoded control fields kept on the outputs
  typedef struct packed {
    logic [2:0] chan;
    logic       single;
    logic [1:0] pd;
  } ctlFields_t;
endpackage

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int RES_BITS   = 12,
  parameter int SHORT_BITS = 8
) (
  input  logic       dclk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       din,
  input  logic       shortRes,
  output seqStrobe_t st,
  output logic       acqActive,
  output logic       holdActive
);
  localparam int CNT_W = $clog2(RES_BITS + 1);

  logic             rxBusy;
  logic [2:0]       rxCnt;
  logic             convActive;
  logic [CNT_W-1:0] convCnt;
  logic [CNT_W-1:0] lastCnt;
  logic             byteDone;

  assign byteDone = rxBusy && (rxCnt == 3'd7);
  assign lastCnt  = shortRes ? CNT_W'(SHORT_BITS) : CNT_W'(RES_BITS);

  always_comb begin
    st         = '0;
    st.shiftIn = !csN && (rxBusy || din);
    st.loadCtl = !csN && byteDone;
    st.drive   = convActive && (convCnt != '0);
    if (st.drive) st.bitSel = SEL_W'(RES_BITS - int'(convCnt));
  end

  // Receive side: start-bit hunt and bit counting
  always_ff @(posedge dclk or negedge rstN) begin
    if (!rstN) begin
      rxBusy <= 1'b0;
      rxCnt  <= '0;
    end else if (csN) begin
      rxBusy <= 1'b0;
      rxCnt  <= '0;
    end else if (!rxBusy) begin
      if (din) begin
        rxBusy <= 1'b1;
        rxCnt  <= 3'd1;
      end
    end else if (byteDone) begin
      rxBusy <= 1'b0;
      rxCnt  <= '0;
    end else begin
      rxCnt <= rxCnt + 3'd1;
    end
  end

  // Conversion side: busy bit then one result bit per clock
  always_ff @(posedge dclk or negedge rstN) begin
    if (!rstN) begin
      convActive <= 1'b0;
      convCnt    <= '0;
    end else if (csN) begin
      convActive <= 1'b0;
      convCnt    <= '0;
    end else if (byteDone) begin
      convActive <= 1'b1;
      convCnt    <= '0;
    end else if (convActive) begin
      if (convCnt == lastCnt) begin
        convActive <= 1'b0;
        convCnt    <= '0;
      end else begin
        convCnt <= convCnt + CNT_W'(1);
      end
    end
  end

  assign acqActive  = rxBusy && (rxCnt >= 3'd4);
  assign holdActive = convActive;

  // R3: the acquire window opens only after the fourth byte bit
  assert_acq_window_R3: assert property (@(posedge dclk) disable iff (!rstN)
    $rose(acqActive) |-> ($past(rxCnt) == 3'd3));

  // R4: a finished byte starts the hold phase from the busy slot
  assert_hold_start_R4: assert property (@(posedge dclk) disable iff (!rstN)
    st.loadCtl |=> (holdActive && (convCnt == '0)));

  // R6: the bit counter never runs past the full resolution
  assert_conv_bound_R6: assert property (@(posedge dclk) disable iff (!rstN)
    holdActive |-> (convCnt <= CNT_W'(RES_BITS)));

  // R8: chip select high empties both phases
  assert_cs_clears_R8: assert property (@(posedge dclk) disable iff (!rstN)
    csN |=> (!acqActive && !holdActive));
endmodule

// File: rtl/sadc_datapath.sv
module sadc_datapath
  import sadc_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                dclk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                din,
  input  logic                modePin,
  input  logic [RES_BITS-1:0] sampleIn,
  input  seqStrobe_t          st,
  output logic [2:0]          chanSel,
  output logic                singleEnded,
  output logic [1:0]          pwrDown,
  output logic                shortRes,
  output logic                dout
);
  logic [5:0]          shiftReg;
  logic [6:0]          ctlBits;
  ctlFields_t          ctl;
  logic [RES_BITS-1:0] heldSample;

  // Bits after the start bit: chan[2:0], mode, single, pd[1:0]
  assign ctlBits = {shiftReg, din};

  always_ff @(posedge dclk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      ctl        <= '0;
      shortRes   <= 1'b0;
      heldSample <= '0;
    end else begin
      if (st.shiftIn) shiftReg <= {shiftReg[4:0], din};
      if (st.loadCtl) begin
        ctl.chan   <= ctlBits[6:4];
        ctl.single <= ctlBits[2];
        ctl.pd     <= ctlBits[1:0];
        shortRes   <= modePin && ctlBits[3];
        heldSample <= sampleIn;
      end
    end
  end

  always_ff @(negedge dclk or negedge rstN) begin
    if (!rstN)         dout <= 1'b0;
    else if (csN)      dout <= 1'b0;
    else if (st.drive) dout <= heldSample[st.bitSel];
    else               dout <= 1'b0;
  end

  assign chanSel     = ctl.chan;
  assign singleEnded = ctl.single;
  assign pwrDown     = ctl.pd;

  // R9: fields move only on the edge that completes a byte
  assert_fields_stable_R9: assert property (@(posedge dclk) disable iff (!rstN)
    !$past(st.loadCtl) |-> $stable(ctl));

  // R6: reduced resolution needs the pin high at the completing edge
  assert_short_needs_pin_R6: assert property (@(posedge dclk) disable iff (!rstN)
    (st.loadCtl && !modePin) |=> !shortRes);
endmodule

// File: rtl/sadc_port.sv
module sadc_port
  import sadc_pkg::*;
#(
  parameter int RES_BITS   = 12,
  parameter int SHORT_BITS = 8
) (
  input  logic                dclk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                din,
  input  logic                modePin,
  input  logic [RES_BITS-1:0] sampleIn,
  output logic                dout,
  output logic                doutOe,
  output logic [2:0]          chanSel,
  output logic                singleEnded,
  output logic [1:0]          pwrDown,
  output logic                acqActive,
  output logic                holdActive
);
  seqStrobe_t st;
  logic       shortRes;

  sadc_ctrl #(.RES_BITS(RES_BITS), .SHORT_BITS(SHORT_BITS)) uCtrl (
    .dclk(dclk), .rstN(rstN), .csN(csN), .din(din), .shortRes(shortRes),
    .st(st), .acqActive(acqActive), .holdActive(holdActive)
  );

  sadc_datapath #(.RES_BITS(RES_BITS)) uData (
    .dclk(dclk), .rstN(rstN), .csN(csN), .din(din), .modePin(modePin),
    .sampleIn(sampleIn), .st(st), .chanSel(chanSel),
    .singleEnded(singleEnded), .pwrDown(pwrDown), .shortRes(shortRes),
    .dout(dout)
  );

  assign doutOe = !csN;
endmodule

// File: tb/sadc_port_test.sv
module sadc_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int SEQ_MAX = 64;

  logic clk = 1'b0;
  logic rstN, csN, din, modePin;
  logic [11:0] sampleIn;
  logic dout, doutOe, singleEnded, acqActive, holdActive;
  logic [2:0] chanSel;
  logic [1:0] pwrDown;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic        dinSeq  [SEQ_MAX];
  logic        csSeq   [SEQ_MAX];
  logic [11:0] sampSeq [SEQ_MAX];
  logic        expDout [SEQ_MAX];
  logic        expAcq  [SEQ_MAX];
  logic        expHold [SEQ_MAX];
  logic [6:0]  expFld  [SEQ_MAX];
  logic [6:0]  curFld = '0;
  int          seqLen;

  sadc_port uut (
    .dclk(clk), .rstN(rstN), .csN(csN), .din(din), .modePin(modePin),
    .sampleIn(sampleIn), .dout(dout), .doutOe(doutOe), .chanSel(chanSel),
    .singleEnded(singleEnded), .pwrDown(pwrDown), .acqActive(acqActive),
    .holdActive(holdActive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic clearSeq();
    for (int c = 0; c < SEQ_MAX; c++) begin
      dinSeq[c]  = 1'b0;
      csSeq[c]   = 1'b0;
      sampSeq[c] = 12'(c * 291 + 77);
      expDout[c] = 1'b0;
      expAcq[c]  = 1'b0;
      expHold[c] = 1'b0;
      expFld[c]  = curFld;
    end
  endtask

  // Frame with start bit on cycle c0: expected values from R3..R6
  task automatic addFrame(input int c0, input logic [7:0] b, input logic [11:0] v, input bit mp);
    int n;
    n = (mp && b[3]) ? 8 : 12;
    for (int i = 0; i < 8; i++) dinSeq[c0 + i] = b[7 - i];
    sampSeq[c0 + 7] = v;
    for (int i = 3; i <= 6; i++) expAcq[c0 + i] = 1'b1;
    for (int i = 7; i <= 7 + n; i++) expHold[c0 + i] = 1'b1;
    for (int j = 0; j < n; j++) expDout[c0 + 8 + j] = v[11 - j];
    for (int c = c0 + 7; c < SEQ_MAX; c++) expFld[c] = b[6:0];
    curFld = b[6:0];
  endtask

  task automatic abortAt(input int c, input int w);
    for (int i = c; i < c + w; i++) csSeq[i] = 1'b1;
    for (int i = c; i < SEQ_MAX; i++) begin
      expAcq[i] = 1'b0;
      expHold[i] = 1'b0;
      expDout[i] = 1'b0;
    end
  endtask

  task automatic runSeq(input bit mp, input string tag);
    logic [5:0] fldExp;
    modePin = mp;
    for (int c = 0; c < seqLen; c++) begin
      din = dinSeq[c];
      csN = csSeq[c];
      sampleIn = sampSeq[c];
      @(posedge clk); #1;
      fldExp = {expFld[c][6:4], expFld[c][2], expFld[c][1:0]};
      check(acqActive == expAcq[c], $sformatf("%s R3 acq cyc %0d", tag, c), acqActive, expAcq[c]);
      check(holdActive == expHold[c], $sformatf("%s R4 R6 hold cyc %0d", tag, c), holdActive, expHold[c]);
      check({chanSel, singleEnded, pwrDown} == fldExp, $sformatf("%s R4 R9 fields cyc %0d", tag, c),
            {chanSel, singleEnded, pwrDown}, fldExp);
      @(negedge clk); #1;
      check(dout == expDout[c], $sformatf("%s R5 R6 dout cyc %0d", tag, c), dout, expDout[c]);
      check(doutOe == !csSeq[c], $sformatf("%s R8 oe cyc %0d", tag, c), doutOe, !csSeq[c]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; csN = 1'b0; din = 1'b1; modePin = 1'b1; sampleIn = 12'hFFF;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    check({acqActive, holdActive} == 2'b00, "R1 flags in reset", {acqActive, holdActive}, 0);
    check({chanSel, singleEnded, pwrDown} == 6'd0, "R1 fields in reset", {chanSel, singleEnded, pwrDown}, 0);
    check(dout == 1'b0, "R1 dout in reset", dout, 0);
    din = 1'b0;
    @(negedge clk); #1;
    rstN = 1'b1;
    check({acqActive, holdActive, dout} == 3'b000, "R1 after release", {acqActive, holdActive, dout}, 0);

    // R2 R5 R6: every control byte, both mode pin levels, varied idle lead-in
    for (int b7 = 0; b7 < 128; b7++) begin
      for (int mp = 0; mp < 2; mp++) begin
        int lead;
        lead = (b7 + mp) % 5;
        clearSeq();
        addFrame(lead, {1'b1, 7'(b7)}, 12'(b7 * 53 + mp * 1111 + 9), bit'(mp));
        seqLen = lead + 24;
        runSeq(bit'(mp), "R2 sweep");
      end
    end

    // R7: overlapped frames at 12 bits, start bits 15 clocks apart
    clearSeq();
    addFrame(1, 8'b1010_0110, 12'hA5C, 1'b0);
    addFrame(16, 8'b1101_1001, 12'h3C7, 1'b0);
    seqLen = 16 + 24;
    runSeq(1'b0, "R7 overlap12");

    // R7: overlapped frames at 8 bits, start bits 11 clocks apart
    clearSeq();
    addFrame(1, 8'b1011_1100, 12'hF0F, 1'b1);
    addFrame(12, 8'b1100_1011, 12'h6B2, 1'b1);
    addFrame(23, 8'b1001_1110, 12'h1E4, 1'b1);
    seqLen = 23 + 24;
    runSeq(1'b1, "R7 overlap8");

    // R8 R9: partial byte abandoned by chip select, then a full frame
    clearSeq();
    for (int i = 2; i <= 5; i++) dinSeq[i] = 1'b1;
    expAcq[5] = 1'b1;
    csSeq[6] = 1'b1;
    csSeq[7] = 1'b1;
    addFrame(10, 8'b1001_0101, 12'h8E1, 1'b0);
    seqLen = 10 + 24;
    runSeq(1'b0, "R8 R9 byte abort");

    // R8: conversion abandoned mid shift-out, then a new frame
    clearSeq();
    addFrame(1, 8'b1110_0011, 12'hC3A, 1'b0);
    abortAt(12, 2);
    addFrame(20, 8'b1010_1101, 12'h57D, 1'b1);
    seqLen = 20 + 24;
    runSeq(1'b1, "R8 conv abort");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule